// File: doc/BRIEF.md
# Configuration image header checker

This block sits between a serial-flash reader and the configuration logic of a device. It accepts the stored configuration image one byte at a time and checks the security header at the front of the image. The checks are a fixed 4-byte magic word, a 16-byte device signature held in a parameter, and a 4-byte payload length that must not be zero. When every header byte has been consumed without a failed check, the block forwards exactly the captured number of payload bytes to the configuration logic, and then it raises a completion flag.

Any failed check puts the block into an error state. In that state the block stops accepting bytes and forwards nothing, and only reset clears it. The block does not compute the 48-byte hash that lies in the header. It flags each hash byte as it is consumed and reports the hash field's offset and length on constant outputs, so that a separate hashing unit can find the field.

Both byte streams use a valid/ready handshake. The input is accepted only while the payload side is ready, so backpressure from downstream stalls header consumption as well as payload forwarding.

Top module: `cfg_hdr_check`

## Requirements
- R1: After reset the block is in the header phase with `hdr_ok`, `done`, `err` and `out_valid` low, and `in_ready` follows `out_ready`.
- R2: Header bytes 0 to 3 must be 0x11, 0x22, 0x33, 0x44 in that order, which is the magic value taken most significant byte first. A mismatching byte puts the block in the error state on the cycle after it is accepted.
- R3: Header bytes 4 to 19 must equal the ASCII signature parameter, with its first character at byte 4. Any mismatch leads to the error state.
- R4: Header bytes 20 to 23 carry the payload length, most significant byte first. A length of zero leads to the error state once byte 23 is accepted.
- R5: The error state is sticky until reset. While in it, `in_ready` and `out_valid` stay low and `hdr_ok` and `done` stay low.
- R6: The content of header bytes 24 to 511 never causes an error.
- R7: `hash_byte` is high exactly when a header byte at offsets 464 to 511 is accepted. `hash_ofs` reads 464 and `hash_len` reads 48.
- R8: No header byte appears on the output. After the 512-byte header, exactly the captured number of payload bytes are forwarded unchanged and in order.
- R9: After the last payload byte, `done` is high and stays high, and `in_ready` stays low.
- R10: While `out_ready` is low, `in_ready` is low in every state.
- R11: `hdr_ok` goes high on the cycle after the last header byte is accepted with no failed check, and it stays high through the payload and completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_data | input | 8 | Image byte from the flash reader |
| in_valid | input | 1 | Image byte is valid |
| in_ready | output | 1 | Block accepts the image byte |
| out_data | output | 8 | Payload byte to the configuration logic |
| out_valid | output | 1 | Payload byte is valid |
| out_ready | input | 1 | Configuration logic accepts the payload byte |
| hash_byte | output | 1 | The byte accepted this cycle belongs to the hash field |
| hdr_ok | output | 1 | Header passed all checks |
| done | output | 1 | All payload bytes have been forwarded |
| err | output | 1 | Latched header error |
| hash_ofs | output | 10 | Byte offset of the hash field |
| hash_len | output | 10 | Length of the hash field in bytes |

## Verification
The hardest situations to reach from the ports are a single corrupted byte deep in the signature and a length field that is zero in all four bytes. In both cases the block must fail at exactly the right byte, with filler and hash bytes that are random and never harmful. The bench builds images through a function that yields a correct header byte for any offset. It then flips one chosen byte, or zeroes the length, and runs the stream under random input gaps and random downstream stalls. A length whose byte-reversed value would be huge shows whether the length is taken most significant byte first, because a wrong byte order means completion never arrives.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_PAY  = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } chk_state_e;
endpackage

// File: rtl/cfg_hdr_fields.sv
// Offset decode for the header: which field the current byte belongs to,
// and whether a checked byte holds its expected value.
module cfg_hdr_fields #(
  parameter int unsigned MAGIC_BYTES = 4,
  parameter int unsigned SIG_BYTES   = 16,
  parameter int unsigned LEN_BYTES   = 4,
  parameter int unsigned HASH_OFS    = 464,
  parameter int unsigned HASH_BYTES  = 48,
  parameter int unsigned OFS_W       = 10,
  parameter logic [8*MAGIC_BYTES-1:0] MAGIC     = 32'h11223344,
  parameter logic [8*SIG_BYTES-1:0]   SIGNATURE = "CFGIMAGE-DEV-001"
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       byte_in,
  output logic             is_chk,
  output logic             chk_match,
  output logic             is_len,
  output logic             is_len_last,
  output logic             is_hash,
  output logic             is_hdr_last
);
  localparam int unsigned CHK_BYTES = MAGIC_BYTES + SIG_BYTES;
  localparam int unsigned CHK_W     = $clog2(CHK_BYTES);
  localparam int unsigned TBL_N     = 2 ** CHK_W;
  localparam int unsigned HDR_BYTES = HASH_OFS + HASH_BYTES;

  localparam logic [OFS_W-1:0] CHK_END   = OFS_W'(CHK_BYTES);
  localparam logic [OFS_W-1:0] LEN_END   = OFS_W'(CHK_BYTES + LEN_BYTES);
  localparam logic [OFS_W-1:0] LEN_LAST  = OFS_W'(CHK_BYTES + LEN_BYTES - 1);
  localparam logic [OFS_W-1:0] HASH_BEG  = OFS_W'(HASH_OFS);
  localparam logic [OFS_W-1:0] HDR_LAST  = OFS_W'(HDR_BYTES - 1);

  logic [7:0]       exp_tbl [TBL_N];
  logic [CHK_W-1:0] idx;

  for (genvar g = 0; g < MAGIC_BYTES; g++) begin : g_magic
    assign exp_tbl[g] = MAGIC[8*(MAGIC_BYTES-1-g) +: 8];
  end
  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
    assign exp_tbl[MAGIC_BYTES+g] = SIGNATURE[8*(SIG_BYTES-1-g) +: 8];
  end
  for (genvar g = CHK_BYTES; g < TBL_N; g++) begin : g_pad
    assign exp_tbl[g] = 8'h00;
  end

  assign idx = ofs[CHK_W-1:0];

  always_comb begin
    is_chk      = (ofs < CHK_END);
    chk_match   = (exp_tbl[idx] == byte_in);
    is_len      = (ofs >= CHK_END) && (ofs < LEN_END);
    is_len_last = (ofs == LEN_LAST);
    is_hash     = (ofs >= HASH_BEG);
    is_hdr_last = (ofs == HDR_LAST);
  end
endmodule

// File: rtl/cfg_hdr_len.sv
// Captures the payload length and counts down the forwarded payload bytes.
module cfg_hdr_len #(
  parameter int unsigned LEN_BYTES = 4,
  localparam int unsigned LEN_W    = 8 * LEN_BYTES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic [7:0] cap_byte,
  input  logic       load,
  input  logic       dec,
  output logic       len_zero,
  output logic       last_beat
);
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] len_shift;

  assign len_shift = {len_q[LEN_W-9:0], cap_byte};
  assign len_zero  = (len_shift == '0);
  assign last_beat = (rem_q == LEN_W'(1));

  always_comb begin
    len_d = len_q;
    rem_d = rem_q;
    if (cap_en) len_d = len_shift;
    if (load)      rem_d = len_q;
    else if (dec)  rem_d = rem_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      rem_q <= '0;
    end else begin
      if (cap_en)      len_q <= len_d;
      if (load || dec) rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/cfg_hdr_check.sv
module cfg_hdr_check
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned MAGIC_BYTES = 4,
  parameter int unsigned SIG_BYTES   = 16,
  parameter int unsigned LEN_BYTES   = 4,
  parameter int unsigned HASH_OFS    = 464,
  parameter int unsigned HASH_BYTES  = 48,
  parameter logic [8*MAGIC_BYTES-1:0] MAGIC     = 32'h11223344,
  parameter logic [8*SIG_BYTES-1:0]   SIGNATURE = "CFGIMAGE-DEV-001",
  localparam int unsigned HDR_BYTES = HASH_OFS + HASH_BYTES,
  localparam int unsigned OFS_W     = $clog2(HDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             hash_byte,
  output logic             hdr_ok,
  output logic             done,
  output logic             err,
  output logic [OFS_W-1:0] hash_ofs,
  output logic [OFS_W-1:0] hash_len
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  chk_state_e       state_q, state_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             ofs_en;
  logic             beat;

  logic f_chk, f_match, f_len, f_len_last, f_hash, f_hdr_last;
  logic len_zero, last_beat;
  logic hdr_beat, pay_beat, len_load;

  cfg_hdr_fields #(
    .MAGIC_BYTES (MAGIC_BYTES),
    .SIG_BYTES   (SIG_BYTES),
    .LEN_BYTES   (LEN_BYTES),
    .HASH_OFS    (HASH_OFS),
    .HASH_BYTES  (HASH_BYTES),
    .OFS_W       (OFS_W),
    .MAGIC       (MAGIC),
    .SIGNATURE   (SIGNATURE)
  ) i_fields (
    .ofs         (ofs_q),
    .byte_in     (in_data),
    .is_chk      (f_chk),
    .chk_match   (f_match),
    .is_len      (f_len),
    .is_len_last (f_len_last),
    .is_hash     (f_hash),
    .is_hdr_last (f_hdr_last)
  );

  cfg_hdr_len #(
    .LEN_BYTES (LEN_BYTES)
  ) i_len (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cap_en    (hdr_beat && f_len),
    .cap_byte  (in_data),
    .load      (len_load),
    .dec       (pay_beat),
    .len_zero  (len_zero),
    .last_beat (last_beat)
  );

  // handshake: downstream readiness gates every byte taken from the input
  assign in_ready  = out_ready && ((state_q == ST_HDR) || (state_q == ST_PAY));
  assign beat      = in_valid && in_ready;
  assign hdr_beat  = beat && (state_q == ST_HDR);
  assign pay_beat  = beat && (state_q == ST_PAY);
  assign out_valid = in_valid && (state_q == ST_PAY);
  assign out_data  = in_data;
  assign hash_byte = hdr_beat && f_hash;

  assign hdr_ok   = (state_q == ST_PAY) || (state_q == ST_DONE);
  assign done     = (state_q == ST_DONE);
  assign err      = (state_q == ST_ERR);
  assign hash_ofs = OFS_W'(HASH_OFS);
  assign hash_len = OFS_W'(HASH_BYTES);

  always_comb begin
    state_d  = state_q;
    ofs_d    = ofs_q;
    ofs_en   = 1'b0;
    len_load = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        if (hdr_beat) begin
          ofs_en = 1'b1;
          ofs_d  = ofs_q + OFS_W'(1);
          if ((f_chk && !f_match) || (f_len_last && len_zero)) begin
            state_d = ST_ERR;
          end else if (f_hdr_last) begin
            state_d  = ST_PAY;
            len_load = 1'b1;
          end
        end
      end
      ST_PAY: begin
        if (pay_beat && last_beat) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_DONE;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_HDR;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ofs_en) ofs_q <= ofs_d;
    end
  end
endmodule

// File: rtl/cfg_hdr_check_sva.sv
module cfg_hdr_check_sva (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic hash_byte,
  input logic hdr_ok,
  input logic done,
  input logic err
);
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r5_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!in_ready && !out_valid && !hdr_ok && !done));
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);
  a_r8_no_hdr_out: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_ok |-> !out_valid);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !in_ready));
  a_r11_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok |=> hdr_ok);
  a_r7_hash_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    hash_byte |-> (in_valid && in_ready && !hdr_ok));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err, hdr_ok}));
endmodule

bind cfg_hdr_check cfg_hdr_check_sva i_sva (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .hash_byte (hash_byte),
  .hdr_ok    (hdr_ok),
  .done      (done),
  .err       (err)
);

// File: tb/test_cfg_hdr_check.sv
module test_cfg_hdr_check;
  localparam logic [31:0]  MAGIC = 32'h11223344;
  localparam logic [127:0] SIG   = "CFGIMAGE-DEV-001";
  localparam int HDR_N = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       hash_byte, hdr_ok, done, err;
  logic [9:0] hash_ofs, hash_len;

  int n_chk = 0;
  int n_fail = 0;
  int stall_pct = 25;
  int unused_seed;

  always #10 clk = ~clk;

  cfg_hdr_check i_cfg_hdr_check (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .hash_byte(hash_byte), .hdr_ok(hdr_ok),
    .done(done), .err(err), .hash_ofs(hash_ofs), .hash_len(hash_len)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] good_byte(input int pos, input logic [31:0] len);
    if (pos < 4)       return MAGIC[8*(3-pos) +: 8];
    else if (pos < 20) return SIG[8*(15-(pos-4)) +: 8];
    else if (pos < 24) return len[8*(23-pos) +: 8];
    else               return 8'($urandom_range(0, 255));
  endfunction

  function automatic bit exp_hash(input int pos);
    return (pos >= 464) && (pos < 512);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // offers one byte with random gaps and stalls until it is taken
  task automatic send_byte(input logic [7:0] b, input int pos, input bit pay);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 99) >= stall_pct);
      in_valid  = ($urandom_range(0, 4) != 0);
      in_data   = b;
      #1;
      if (!out_ready) check(in_ready == 1'b0, "R10", "in_ready under stall", longint'(in_ready), 0);
      if (in_valid && in_ready) begin
        acc = 1'b1;
        if (pay) begin
          check(out_valid == 1'b1, "R8", "payload valid", longint'(out_valid), 1);
          check(out_data == b, "R8", "payload data", longint'(out_data), longint'(b));
        end else begin
          check(out_valid == 1'b0, "R8", "header not forwarded", longint'(out_valid), 0);
          check(hash_byte == exp_hash(pos), "R7", "hash flag", longint'(hash_byte), longint'(exp_hash(pos)));
        end
      end
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
  endtask

  // sends the header; bad_pos >= 0 flips one byte; stops after a failing byte
  task automatic send_header(input logic [31:0] len, input int bad_pos);
    for (int i = 0; i < HDR_N; i++) begin
      logic [7:0] b = good_byte(i, len);
      if (i == bad_pos) b = b ^ 8'h01;
      send_byte(b, i, 1'b0);
      if (i == bad_pos && i < 20) return;
      if (len == 32'd0 && i == 23) return;
    end
  endtask

  task automatic expect_error(input string req);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    #1;
    check(err == 1'b1, req, "err set", longint'(err), 1);
    check(in_ready == 1'b0, "R5", "in_ready in error", longint'(in_ready), 0);
    check(hdr_ok == 1'b0, "R5", "hdr_ok in error", longint'(hdr_ok), 0);
    repeat (10) @(negedge clk);
    #1;
    check(err == 1'b1 && out_valid == 1'b0 && in_ready == 1'b0, "R5",
          "error sticky", longint'({err, out_valid, in_ready}), 3'b100);
    in_valid = 1'b0;
  endtask

  task automatic good_image(input logic [31:0] len);
    send_header(len, -1);
    @(negedge clk); #1;
    check(hdr_ok == 1'b1, "R11", "hdr_ok after header", longint'(hdr_ok), 1);
    check(err == 1'b0, "R6", "unchecked bytes harmless", longint'(err), 0);
    for (int k = 0; k < int'(len); k++) begin
      if (k == int'(len) - 1) begin
        @(negedge clk); #1;
        check(done == 1'b0, "R8", "not done before last byte", longint'(done), 0);
      end
      send_byte(8'($urandom_range(0, 255)), k, 1'b1);
    end
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    #1;
    check(done == 1'b1, "R9", "done after payload", longint'(done), 1);
    check(in_ready == 1'b0, "R9", "in_ready after done", longint'(in_ready), 0);
    check(out_valid == 1'b0, "R9", "no forward after done", longint'(out_valid), 0);
    check(hdr_ok == 1'b1, "R11", "hdr_ok held", longint'(hdr_ok), 1);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    unused_seed = $urandom(32'd1234);
    do_reset();
    // R1 reset state
    out_ready = 1'b1; #1;
    check(in_ready == 1'b1, "R1", "in_ready", longint'(in_ready), 1);
    check({hdr_ok, done, err, out_valid} == 4'b0, "R1", "flags",
          longint'({hdr_ok, done, err, out_valid}), 0);
    out_ready = 1'b0; #1;
    check(in_ready == 1'b0, "R1", "in_ready follows out_ready", longint'(in_ready), 0);
    check(hash_ofs == 10'd464, "R7", "hash_ofs", longint'(hash_ofs), 464);
    check(hash_len == 10'd48, "R7", "hash_len", longint'(hash_len), 48);

    // directed cases
    good_image(32'd5);
    do_reset(); send_header(32'd5, 2);  expect_error("R2");
    do_reset(); send_header(32'd5, 19); expect_error("R3");
    do_reset(); send_header(32'd0, -1); expect_error("R4");
    do_reset(); good_image(32'd1);
    do_reset(); stall_pct = 60; good_image(32'h0000_0103); stall_pct = 25;

    // constrained random mix
    for (int it = 0; it < 6; it++) begin
      int kind = $urandom_range(0, 3);
      do_reset();
      case (kind)
        0: good_image(32'($urandom_range(1, 40)));
        1: begin send_header(32'd7, $urandom_range(0, 3));  expect_error("R2"); end
        2: begin send_header(32'd7, $urandom_range(4, 19)); expect_error("R3"); end
        default: begin send_header(32'd0, -1); expect_error("R4"); end
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule